// File: doc/BRIEF.md
# Mapper Register Write Decoder with Scanline Interrupt

This block sits on the CPU write path of a cartridge bank mapper. Each write strobe carries a 16-bit address and an 8-bit data byte. The block routes the write into one of the configuration registers it holds:

- up to eight outer configuration bytes, reached in the `$5xxx` window;
- twelve inner bank bytes;
- a bank-select control byte;
- a mirroring byte;
- a work-RAM configuration byte;
- a data latch;
- the reload value and control of a scanline interrupt counter.

All register contents are driven out in parallel so that the bank-mapping logic downstream can use them directly.

A `$5xxx` write that does not reach the outer registers is not stored. The block raises a pass-through flag in the same cycle, and the work RAM uses that flag to take the write. A soft-reset input puts the registers back to their power-on values. When cycling is enabled, each soft reset also steps a 3-bit switch value. That value picks which address bit qualifies an outer-register write. A variant input selects the small decoding differences between board revisions.

Top module: `mapper_write_decoder`

## Requirements
- R1: After reset, the outputs hold these values:
  - bank bytes 0..11 read 0x00, 0x02, 0x04, 0x05, 0x06, 0x07, 0x00, 0x01, 0xFE, 0xFF, 0xFF, 0xFF;
  - the work-RAM byte reads 0x80;
  - the control, mirroring, latch and outer bytes read 0;
  - the irq output and the switch value read 0.
- R2: A write with address bits 15:12 equal to 0x5 and address bit (4 + switch value) set stores its data in the outer byte whose index is address bits 1:0. On variant 3 the index is address bits 2:0.
- R3: A `$5xxx` write that does not meet R2 changes no register and raises `ram_pass` during its strobe cycle. This also applies when the outer registers are disabled. They are disabled on variant 2 when work-RAM bit 5 is set and bit 6 is clear.
- R4: Every write with address bit 15 set loads the full data byte into the data latch.
- R5: Writes with address bit 15 set are decoded on address bits 15:13 and bit 0:
  - 100/0 is bank select;
  - 100/1 is bank data;
  - 101/0 is mirroring;
  - 101/1 is the work-RAM byte;
  - 110/0 is the irq reload value;
  - 110/1 is a reload request;
  - 111/0 is irq disable-and-acknowledge;
  - 111/1 is irq enable.
- R6: A bank-select or bank-data write with address bit 1 set is ignored. The data latch still loads.
- R7: On variant 2, a bank-select value of 0x46 is stored as 0x47 and 0x47 is stored as 0x46. Other values are stored unchanged.
- R8: A bank-data write goes to the bank byte whose index is the control byte ANDed with a mask. The mask is 0x0F when bit 1 of outer byte 3 is set, and 0x07 otherwise. The write is dropped when the index is 12 or more.
- R9: A work-RAM byte write with data bit 5 clear keeps only data bits 7:6. All other bits are stored as 0.
- R10: On each `line_tick`, the counter behaves as follows:
  - it loads the reload value when it is zero or a reload is pending, and otherwise decrements;
  - the irq is raised when the new count is zero and the interrupt is enabled;
  - the pending reload clears.
- R11: Once raised, `irq` stays high through later ticks and counter reloads. It clears only on a disable write or a reset.
- R12: A soft reset returns every register to its R1 value. The switch value advances by one modulo 8 when `dip_cycle_en` is high, and is otherwise kept. A power-on reset sets the switch value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| soft_rst | input | 1 | Soft reset, one cycle pulse |
| dip_cycle_en | input | 1 | Allows soft reset to step the switch value |
| variant | input | 3 | Board variant select |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One pulse per scanline |
| outer_regs | output | 64 | Outer bytes, byte i at bits 8i+7:8i |
| bank_regs | output | 96 | Bank bytes, byte i at bits 8i+7:8i |
| ctrl | output | 8 | Bank-select control byte |
| mirr | output | 8 | Mirroring byte |
| ram_cfg | output | 8 | Work-RAM configuration byte |
| data_latch | output | 8 | Last data byte written above 0x7FFF |
| dip_sel | output | 3 | Current switch value |
| ram_pass | output | 1 | Current `$5xxx` write goes to work RAM |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:

- `soft_rst` is a single-cycle pulse that does not coincide with a write;
- `line_tick` is a pulse that does not coincide with an interrupt disable write;
- inputs change only away from the rising edge.

The stimulus drives every input at the falling edge and holds each strobe for exactly one cycle. It never overlaps a tick with a write or a soft reset. The one exception is the ordering checks, which the bench does not perform.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

    localparam int DW      = 8;
    localparam int AW      = 16;
    localparam int N_OUTER = 8;
    localparam int N_BANK  = 12;
    localparam int DIP_W   = 3;
    localparam int IDX_W   = $clog2(N_BANK + 4);
    localparam int OIDX_W  = $clog2(N_OUTER);

    typedef enum logic [3:0] {
        K_NONE, K_OUTER, K_RAMPASS, K_SEL, K_DATA, K_MIRR,
        K_RAMCFG, K_IRQVAL, K_IRQLOAD, K_IRQOFF, K_IRQON
    } wr_kind_e;

    typedef struct packed {
        logic [N_OUTER-1:0][DW-1:0] outer;
        logic [N_BANK-1:0][DW-1:0]  bank;
        logic [DW-1:0]              ctrl;
        logic [DW-1:0]              mirr;
        logic [DW-1:0]              ramcfg;
        logic [DW-1:0]              latch;
        logic [DW-1:0]              irq_val;
        logic [DW-1:0]              irq_cnt;
        logic                       irq_pend;
        logic                       irq_en;
        logic                       irq;
        logic [DIP_W-1:0]           dip;
    } state_t;

    // Power-on contents of one bank byte
    function automatic logic [DW-1:0] bank_init(input int idx);
        case (idx)
            0:       return DW'(0);
            1:       return DW'(2);
            2:       return DW'(4);
            3:       return DW'(5);
            4:       return DW'(6);
            5:       return DW'(7);
            6:       return DW'(0);
            7:       return DW'(1);
            8:       return DW'(8'hFE);
            default: return DW'(8'hFF);
        endcase
    endfunction

    function automatic state_t reset_state(input logic [DIP_W-1:0] dip);
        state_t s;
        s = '0;
        for (int i = 0; i < N_BANK; i++) s.bank[i] = bank_init(i);
        s.ramcfg = DW'(8'h80);
        s.dip    = dip;
        return s;
    endfunction

endpackage

// File: rtl/mwd_decode.sv
module mwd_decode
    import mwd_pkg::*;
(
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DIP_W-1:0]  dip,
    input  logic [2:0]        variant,
    input  logic              outer_on,
    output wr_kind_e          kind,
    output logic [OIDX_W-1:0] outer_idx,
    output logic              hi_write
);
    localparam logic [AW-1:0] QUAL_BASE = AW'(16);

    logic qual_hit;

    always_comb begin
        qual_hit  = |(addr & (QUAL_BASE << dip));
        outer_idx = (variant == 3'd3) ? OIDX_W'(addr[2:0]) : OIDX_W'(addr[1:0]);
        hi_write  = wr_en && addr[15];
        kind      = K_NONE;
        if (wr_en && addr[15:12] == 4'h5) begin
            kind = (outer_on && qual_hit) ? K_OUTER : K_RAMPASS;
        end else if (hi_write) begin
            case ({addr[14:13], addr[0]})
                3'b000:  kind = addr[1] ? K_NONE : K_SEL;
                3'b001:  kind = addr[1] ? K_NONE : K_DATA;
                3'b010:  kind = K_MIRR;
                3'b011:  kind = K_RAMCFG;
                3'b100:  kind = K_IRQVAL;
                3'b101:  kind = K_IRQLOAD;
                3'b110:  kind = K_IRQOFF;
                default: kind = K_IRQON;
            endcase
        end
    end
endmodule

// File: rtl/mwd_irq_step.sv
module mwd_irq_step
    import mwd_pkg::*;
(
    input  logic          tick,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] reload_val,
    input  logic          pend,
    input  logic          en,
    output logic [DW-1:0] cnt_next,
    output logic          fire
);
    always_comb begin
        cnt_next = cnt;
        fire     = 1'b0;
        if (tick) begin
            cnt_next = (cnt == '0 || pend) ? reload_val : cnt - DW'(1);
            fire     = (cnt_next == '0) && en;
        end
    end
endmodule

// File: rtl/mapper_write_decoder.sv
module mapper_write_decoder
    import mwd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  dip_cycle_en,
    input  logic [2:0]            variant,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic                  line_tick,
    output logic [N_OUTER*DW-1:0] outer_regs,
    output logic [N_BANK*DW-1:0]  bank_regs,
    output logic [DW-1:0]         ctrl,
    output logic [DW-1:0]         mirr,
    output logic [DW-1:0]         ram_cfg,
    output logic [DW-1:0]         data_latch,
    output logic [DIP_W-1:0]      dip_sel,
    output logic                  ram_pass,
    output logic                  irq
);
    localparam logic [DW-1:0] SWAP_A   = DW'(8'h46);
    localparam logic [DW-1:0] SWAP_B   = DW'(8'h47);
    localparam int            EXT_REG  = 3;
    localparam int            EXT_BIT  = 1;

    state_t             s_q, s_d;
    wr_kind_e           kind;
    logic [OIDX_W-1:0]  outer_idx;
    logic               hi_write;
    logic               outer_on;
    logic [DW-1:0]      cnt_next;
    logic               fire;
    logic [IDX_W-1:0]   data_idx;
    logic [DW-1:0]      sel_val;

    assign outer_on = s_q.ramcfg[6] || !(s_q.ramcfg[5] && variant == 3'd2);

    mwd_decode u_decode (
        .wr_en     (wr_en),
        .addr      (wr_addr),
        .dip       (s_q.dip),
        .variant   (variant),
        .outer_on  (outer_on),
        .kind      (kind),
        .outer_idx (outer_idx),
        .hi_write  (hi_write)
    );

    mwd_irq_step u_irq (
        .tick       (line_tick),
        .cnt        (s_q.irq_cnt),
        .reload_val (s_q.irq_val),
        .pend       (s_q.irq_pend),
        .en         (s_q.irq_en),
        .cnt_next   (cnt_next),
        .fire       (fire)
    );

    always_comb begin
        s_d = s_q;

        // index into the bank bytes; wider mask in extended mode
        data_idx = s_q.outer[EXT_REG][EXT_BIT] ? IDX_W'(s_q.ctrl[3:0])
                                               : IDX_W'(s_q.ctrl[2:0]);
        sel_val  = wr_data;
        if (variant == 3'd2 && wr_data == SWAP_A) sel_val = SWAP_B;
        if (variant == 3'd2 && wr_data == SWAP_B) sel_val = SWAP_A;

        // scanline counter
        s_d.irq_cnt = cnt_next;
        if (line_tick) s_d.irq_pend = 1'b0;
        if (fire)      s_d.irq      = 1'b1;

        if (hi_write) s_d.latch = wr_data;

        case (kind)
            K_OUTER:   s_d.outer[outer_idx] = wr_data;
            K_SEL:     s_d.ctrl = sel_val;
            K_DATA:    if (data_idx < IDX_W'(N_BANK)) s_d.bank[data_idx] = wr_data;
            K_MIRR:    s_d.mirr = wr_data;
            K_RAMCFG:  s_d.ramcfg = wr_data[5] ? wr_data : {wr_data[7:6], 6'b0};
            K_IRQVAL:  s_d.irq_val = wr_data;
            K_IRQLOAD: s_d.irq_pend = 1'b1;
            K_IRQOFF:  begin s_d.irq_en = 1'b0; s_d.irq = 1'b0; end
            K_IRQON:   s_d.irq_en = 1'b1;
            default:   ;
        endcase

        if (soft_rst)
            s_d = reset_state(s_q.dip + DIP_W'(dip_cycle_en));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= reset_state('0);
        else        s_q <= s_d;
    end

    assign outer_regs = s_q.outer;
    assign bank_regs  = s_q.bank;
    assign ctrl       = s_q.ctrl;
    assign mirr       = s_q.mirr;
    assign ram_cfg    = s_q.ramcfg;
    assign data_latch = s_q.latch;
    assign dip_sel    = s_q.dip;
    assign irq        = s_q.irq;
    assign ram_pass   = (kind == K_RAMPASS);

endmodule

// File: rtl/mwd_checker.sv
module mwd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        dip_cycle_en,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        line_tick,
    input logic        irq,
    input logic [7:0]  data_latch,
    input logic [7:0]  ram_cfg,
    input logic [2:0]  dip_sel
);
    logic ack_wr;
    assign ack_wr = wr_en && wr_addr[15:13] == 3'b111 && !wr_addr[0];

    p_latch_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15] && !soft_rst) |=> data_latch == $past(wr_data));

    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr && !soft_rst) |=> irq);

    p_irq_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> !irq);

    p_irq_from_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(line_tick));

    p_soft_ramcfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ram_cfg == 8'h80);

    p_dip_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && dip_cycle_en) |=> dip_sel == $past(dip_sel) + 3'd1);

    p_dip_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(soft_rst && dip_cycle_en) |=> $stable(dip_sel));
endmodule

bind mapper_write_decoder mwd_checker i_mwd_checker (.*);

// File: tb/test_mapper_write_decoder.sv
`timescale 1ns/1ps
module test_mapper_write_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        dip_cycle_en = 1'b0;
    logic [2:0]  variant = 3'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_tick = 1'b0;
    logic [63:0] outer_regs;
    logic [95:0] bank_regs;
    logic [7:0]  ctrl, mirr, ram_cfg, data_latch;
    logic [2:0]  dip_sel;
    logic        ram_pass, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    mapper_write_decoder i_mapper_write_decoder (.*);

    // {addr, data, field kind, field index, expected}
    // kinds: 0 latch, 1 ctrl, 2 mirr, 3 ram_cfg, 4 outer[i], 5 bank[i]
    localparam logic [39:0] VEC [0:15] = '{
        {16'h8000, 8'h06, 4'd1, 4'd0,  8'h06},  // R5 select
        {16'h8001, 8'h3C, 4'd5, 4'd6,  8'h3C},  // R5 data
        {16'h8002, 8'h07, 4'd1, 4'd0,  8'h06},  // R6 ignored select
        {16'h8003, 8'h55, 4'd5, 4'd6,  8'h3C},  // R6 ignored data
        {16'hA000, 8'h01, 4'd2, 4'd0,  8'h01},  // R5 mirroring
        {16'hA001, 8'h25, 4'd3, 4'd0,  8'h25},  // R9 bit5 set keeps all
        {16'hA001, 8'hC5, 4'd3, 4'd0,  8'hC0},  // R9 bit5 clear
        {16'h5010, 8'hAB, 4'd4, 4'd0,  8'hAB},  // R2 outer 0
        {16'h5013, 8'h2F, 4'd4, 4'd3,  8'h2F},  // R2 outer 3, extended on
        {16'h8000, 8'h0A, 4'd1, 4'd0,  8'h0A},  // R8 select 10
        {16'h8001, 8'h99, 4'd5, 4'd10, 8'h99},  // R8 extended index 10
        {16'h8000, 8'h0C, 4'd1, 4'd0,  8'h0C},  // R8 select 12
        {16'h8001, 8'h77, 4'd5, 4'd4,  8'h06},  // R8 index 12 dropped
        {16'h5003, 8'h11, 4'd4, 4'd3,  8'h2F},  // R3 qualifier clear
        {16'hE123, 8'h5A, 4'd0, 4'd0,  8'h5A},  // R4 latch
        {16'h9FFE, 8'h12, 4'd1, 4'd0,  8'h0C}   // R6 alias ignored
    };

    function automatic logic [7:0] fld(input logic [3:0] k, input logic [3:0] i);
        case (k)
            4'd0:    return data_latch;
            4'd1:    return ctrl;
            4'd2:    return mirr;
            4'd3:    return ram_cfg;
            4'd4:    return outer_regs[int'(i)*8 +: 8];
            default: return bank_regs[int'(i)*8 +: 8];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // write to $5xxx, checking the pass-through flag mid-cycle
    task automatic write_pass(input logic [15:0] a, input logic [7:0] d, input logic exp_pass);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        #1 check("R3 ram_pass", 32'(ram_pass), 32'(exp_pass));
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_soft();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); line_tick = 1'b1;
        @(negedge clk); line_tick = 1'b0;
    endtask

    task automatic check_defaults(input string req);
        localparam logic [95:0] BANK_INIT =
            96'hFFFFFFFE_01000706_05040200;
        check(req, 32'(bank_regs[31:0]),  32'(BANK_INIT[31:0]));
        check(req, 32'(bank_regs[63:32]), 32'(BANK_INIT[63:32]));
        check(req, 32'(bank_regs[95:64]), 32'(BANK_INIT[95:64]));
        check(req, 32'(ram_cfg), 32'h80);
        check(req, 32'({ctrl, mirr, data_latch}), 32'h0);
        check(req, 32'(outer_regs[31:0]), 32'h0);
        check(req, 32'(outer_regs[63:32]), 32'h0);
        check(req, 32'(irq), 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_defaults("R1 reset");
        check("R1 dip", 32'(dip_sel), 32'h0);

        for (int v = 0; v < 16; v++) begin
            do_write(VEC[v][39:24], VEC[v][23:16]);
            check($sformatf("R2-table vector %0d", v),
                  32'(fld(VEC[v][15:12], VEC[v][11:8])), 32'(VEC[v][7:0]));
        end

        // R12 soft reset without cycling
        do_soft();
        check_defaults("R12 soft reset");
        check("R12 dip kept", 32'(dip_sel), 32'h0);

        // R7 swap on variant 2
        variant = 3'd2;
        do_write(16'h8000, 8'h46);
        check("R7 0x46", 32'(ctrl), 32'h47);
        do_write(16'h8000, 8'h47);
        check("R7 0x47", 32'(ctrl), 32'h46);
        do_write(16'h8000, 8'h45);
        check("R7 other", 32'(ctrl), 32'h45);

        // R3 outer disabled on variant 2
        do_write(16'hA001, 8'h20);
        write_pass(16'h5010, 8'h5A, 1'b1);
        check("R3 disabled outer", 32'(outer_regs[7:0]), 32'h0);
        do_write(16'hA001, 8'h60);
        write_pass(16'h5011, 8'h33, 1'b0);
        check("R2 re-enabled outer", 32'(outer_regs[15:8]), 32'h33);

        // R2 variant 3 index width
        do_soft();
        variant = 3'd3;
        do_write(16'h5016, 8'h44);
        check("R2 variant3 index", 32'(outer_regs[55:48]), 32'h44);
        check("R2 variant3 not 2", 32'(outer_regs[23:16]), 32'h0);
        variant = 3'd0;
        do_write(16'h5016, 8'h55);
        check("R2 variant0 index", 32'(outer_regs[23:16]), 32'h55);

        // R12 dip cycling, R2 qualifier moves
        dip_cycle_en = 1'b1;
        do_soft();
        check("R12 dip step", 32'(dip_sel), 32'h1);
        write_pass(16'h5010, 8'h12, 1'b1);
        check("R3 old qualifier", 32'(outer_regs[7:0]), 32'h0);
        write_pass(16'h5020, 8'h12, 1'b0);
        check("R2 new qualifier", 32'(outer_regs[7:0]), 32'h12);
        for (int k = 0; k < 7; k++) do_soft();
        check("R12 dip wrap", 32'(dip_sel), 32'h0);
        dip_cycle_en = 1'b0;
        do_soft();
        check("R12 dip hold", 32'(dip_sel), 32'h0);

        // R10 counter and R11 sticky irq
        do_write(16'hC000, 8'h03);
        do_write(16'hC001, 8'h00);
        do_write(16'hE001, 8'h00);
        do_tick(); check("R10 tick1 reload", 32'(irq), 32'h0);
        do_tick(); check("R10 tick2", 32'(irq), 32'h0);
        do_tick(); check("R10 tick3", 32'(irq), 32'h0);
        do_tick(); check("R10 tick4 zero", 32'(irq), 32'h1);
        do_tick(); check("R11 held over reload", 32'(irq), 32'h1);
        do_write(16'hE000, 8'h00);
        check("R11 acknowledge", 32'(irq), 32'h0);
        do_tick(); do_tick(); do_tick();
        check("R10 disabled no irq", 32'(irq), 32'h0);

        // R10 zero reload value fires every tick
        do_write(16'hC000, 8'h00);
        do_write(16'hC001, 8'h00);
        do_write(16'hE001, 8'h00);
        do_tick();
        check("R10 zero reload", 32'(irq), 32'h1);
        do_soft();
        check("R11 cleared by reset", 32'(irq), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule